// File: doc/BRIEF.md
# Arithmetic and Logic Unit with Condition Flags

This block is the integer execute stage of a small load/store processor. It takes two 64-bit operands, a shift amount and a 3-bit operation code. Within the same cycle it returns a 64-bit result and four condition indications for that result: negative, zero, signed overflow and carry. The caller reads the operands from its register file and writes the result back. The result path has no register, so a result appears as soon as its inputs settle.

Beside the combinational path sits a 4-bit flag register. It loads the current indications on a rising clock edge, but only when the caller marks the instruction as flag-setting and the operation is add, subtract or AND. Every other instruction leaves the register untouched. A compare is issued as a flag-setting subtract. The caller then discards the result, for example by steering it to the always-zero register, so only the flag register changes.

Top module: `alu_flags_core`

## Requirements
- R1: With op_sel = 0 (add), result equals opa + opb modulo 2^64.
- R2: With op_sel = 1 (subtract), result equals opa - opb modulo 2^64. Subtracting a value from itself gives zero with flag_c = 1.
- R3: op_sel = 2 gives opa AND opb, op_sel = 3 gives opa OR opb, and op_sel = 4 gives opa XOR opb.
- R4: op_sel = 5 shifts opa left by shamt (0 to 63) and op_sel = 6 shifts it right logically by shamt. Vacated bits fill with zero, and opb has no effect on either shift.
- R5: For every operation, flag_n equals result bit 63 and flag_z is 1 exactly when result is zero.
- R6: For add and subtract, flag_v is 1 when the two's-complement result overflows 64 bits. For all other operations it is 0.
- R7: For add, flag_c is the carry out of bit 63. For subtract, flag_c is 1 when no borrow occurs (opa >= opb unsigned). For all other operations it is 0.
- R8: flags_q holds {N, Z, C, V} in bits 3 down to 0. It loads the current flags on a rising clk edge when set_flags = 1 and op_sel is 0, 1 or 2. Otherwise it keeps its value, including when set_flags = 1 with any other operation.
- R9: While rst_n is low, flags_q is 0000. The clear takes effect without waiting for a clock edge.
- R10: op_sel = 7 is reserved. It gives a zero result, so flag_z = 1, and V and C are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| op_sel | input | 3 | Operation code |
| set_flags | input | 1 | Instruction is a flag-setting variant |
| opa | input | 64 | First operand; the value shifted by shift operations |
| opb | input | 64 | Second operand, register or immediate |
| shamt | input | 6 | Shift amount |
| result | output | 64 | Operation result |
| flag_n | output | 1 | Result is negative |
| flag_z | output | 1 | Result is zero |
| flag_c | output | 1 | Carry out / no borrow |
| flag_v | output | 1 | Signed overflow |
| flags_q | output | 4 | Stored flags {N, Z, C, V} |

## Verification
The result and the four current flags are combinational. The bench samples them two time units after it drives the inputs on a falling clock edge, still inside the same cycle. The flag register takes one rising edge, so its expected value is compared at the next falling edge, one cycle after the stimulus. Inputs stay stable across that edge. The reset clear is asynchronous and is checked two time units after rst_n falls, before any clock edge. Operand pairs sweep a set of boundary values through every operation, and shifts sweep all 64 amounts in both directions.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_SHL = 3'd5,
    OP_SHR = 3'd6,
    OP_RSV = 3'd7
  } alu_op_e;

  localparam int FLAG_W = 4;
  localparam int FLAG_N_BIT = 3;
  localparam int FLAG_Z_BIT = 2;
  localparam int FLAG_C_BIT = 1;
  localparam int FLAG_V_BIT = 0;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              carry,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide;

  // Subtract is a + ~b + 1; the carry out then means no borrow.
  always_comb begin
    b_eff = sub ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
    sum   = wide[MSB:0];
    carry = wide[DATA_W];
    ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [1:0]        sel,
  output logic [DATA_W-1:0] res
);
  // sel: 0 AND, 1 OR, 2 XOR, 3 zero
  genvar i;
  generate
    for (i = 0; i < DATA_W; i++) begin : g_bit
      always_comb begin
        unique case (sel)
          2'd0:    res[i] = a[i] & b[i];
          2'd1:    res[i] = a[i] | b[i];
          2'd2:    res[i] = a[i] ^ b[i];
          default: res[i] = 1'b0;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int DATA_W  = 64,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  a,
  input  logic [SHAMT_W-1:0] amt,
  input  logic               left,
  output logic [DATA_W-1:0]  res
);
  // Logarithmic barrel: one stage per amount bit, each stage a fixed shift.
  logic [DATA_W-1:0] stage [SHAMT_W+1];

  assign stage[0] = a;

  genvar k;
  generate
    for (k = 0; k < SHAMT_W; k++) begin : g_stage
      localparam int DIST = 1 << k;
      always_comb begin
        if (!amt[k])
          stage[k+1] = stage[k];
        else if (left)
          stage[k+1] = stage[k] << DIST;
        else
          stage[k+1] = stage[k] >> DIST;
      end
    end
  endgenerate

  assign res = stage[SHAMT_W];
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flags_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [FLAG_W-1:0] d,
  output logic [FLAG_W-1:0] q
);
  logic [FLAG_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (we) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  // R8: a write loads the presented flags
  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == $past(d)));

  // R8: without a write the stored flags stay put
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/alu_flags_core.sv
module alu_flags_core
  import alu_flags_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         op_sel,
  input  logic               set_flags,
  input  logic [DATA_W-1:0]  opa,
  input  logic [DATA_W-1:0]  opb,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [DATA_W-1:0]  result,
  output logic               flag_n,
  output logic               flag_z,
  output logic               flag_c,
  output logic               flag_v,
  output logic [3:0]         flags_q
);
  localparam int MSB = DATA_W - 1;

  alu_op_e           op;
  logic              is_arith, is_shift, flag_op, flag_we;
  logic [1:0]        bw_sel;
  logic [DATA_W-1:0] as_res, bw_res, sh_res;
  logic              as_c, as_v;
  logic [FLAG_W-1:0] flags_d;

  assign op = alu_op_e'(op_sel);

  // Operation decode
  always_comb begin
    is_arith = (op == OP_ADD) || (op == OP_SUB);
    is_shift = (op == OP_SHL) || (op == OP_SHR);
    flag_op  = is_arith || (op == OP_AND);
    flag_we  = set_flags && flag_op;
    unique case (op)
      OP_AND:  bw_sel = 2'd0;
      OP_OR:   bw_sel = 2'd1;
      OP_XOR:  bw_sel = 2'd2;
      default: bw_sel = 2'd3;
    endcase
  end

  alu_addsub #(.DATA_W(DATA_W)) i_addsub (
    .a(opa), .b(opb), .sub(op == OP_SUB),
    .sum(as_res), .carry(as_c), .ovf(as_v)
  );

  alu_bitwise #(.DATA_W(DATA_W)) i_bitwise (
    .a(opa), .b(opb), .sel(bw_sel), .res(bw_res)
  );

  alu_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) i_shifter (
    .a(opa), .amt(shamt), .left(op == OP_SHL), .res(sh_res)
  );

  // Result select and current flags
  always_comb begin
    if (is_arith)      result = as_res;
    else if (is_shift) result = sh_res;
    else               result = bw_res;
    flag_n = result[MSB];
    flag_z = ~|result;
    flag_c = is_arith & as_c;
    flag_v = is_arith & as_v;
    flags_d[FLAG_N_BIT] = flag_n;
    flags_d[FLAG_Z_BIT] = flag_z;
    flags_d[FLAG_C_BIT] = flag_c;
    flags_d[FLAG_V_BIT] = flag_v;
  end

  alu_flag_reg i_flag_reg (
    .clk(clk), .rst_n(rst_n), .we(flag_we), .d(flags_d), .q(flags_q)
  );

  // R2: subtracting equal operands gives zero with no borrow
  p_sub_equal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd1 && opa == opb) |-> (result == '0 && flag_c && !flag_v));

  // R4: a zero shift passes the operand through
  p_shift_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_sel == 3'd5 || op_sel == 3'd6) && shamt == '0) |-> (result == opa));

  // R6 and R7: V and C stay clear outside add and subtract
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel > 3'd1) |-> (!flag_v && !flag_c));

  // R8: flag-setting request on a shift leaves the register alone
  p_shift_keeps_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && op_sel >= 3'd3) |=> $stable(flags_q));

  // R10: reserved code yields zero
  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd7) |-> (result == '0 && flag_z));
endmodule

// File: tb/test_alu_flags_core.sv
module test_alu_flags_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op_sel;
  logic        set_flags;
  logic [63:0] opa, opb;
  logic [5:0]  shamt;
  logic [63:0] result;
  logic        flag_n, flag_z, flag_c, flag_v;
  logic [3:0]  flags_q;

  int checks = 0;
  int fails  = 0;
  logic [3:0] exp_q;

  always #5 clk = ~clk;

  alu_flags_core i_alu_flags_core (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .set_flags(set_flags),
    .opa(opa), .opb(opb), .shamt(shamt), .result(result),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
    .flags_q(flags_q)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Returns {result, N, Z, C, V}
  function automatic logic [67:0] model(input logic [2:0] op, input logic [63:0] x,
                                        input logic [63:0] y, input logic [5:0] s);
    logic [63:0] r;
    logic        c, v;
    c = 1'b0; v = 1'b0;
    case (op)
      3'd0: begin
        r = x + y;
        c = ({1'b0, x} + {1'b0, y}) > 65'h0_FFFF_FFFF_FFFF_FFFF;
        v = (x[63] == y[63]) && (r[63] != x[63]);
      end
      3'd1: begin
        r = x - y;
        c = (x >= y);
        v = (x[63] != y[63]) && (r[63] != x[63]);
      end
      3'd2: r = x & y;
      3'd3: r = x | y;
      3'd4: r = x ^ y;
      3'd5: r = x << s;
      3'd6: r = x >> s;
      default: r = 64'd0;
    endcase
    return {r, r[63], (r == 64'd0), c, v};
  endfunction

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R1 add";
      3'd1: return "R2 sub";
      3'd2, 3'd3, 3'd4: return "R3 logic";
      3'd5, 3'd6: return "R4 shift";
      default: return "R10 reserved";
    endcase
  endfunction

  task automatic run(input logic [2:0] op, input logic [63:0] x, input logic [63:0] y,
                     input logic [5:0] s, input bit sf);
    logic [67:0] m;
    @(negedge clk);
    op_sel = op; opa = x; opb = y; shamt = s; set_flags = sf;
    #2;
    m = model(op, x, y, s);
    chk(result == m[67:4], op_tag(op), result, m[67:4]);
    chk({flag_n, flag_z, flag_c, flag_v} == m[3:0], "R5/R6/R7 flags",
        {60'd0, flag_n, flag_z, flag_c, flag_v}, {60'd0, m[3:0]});
    if (sf && op <= 3'd2) exp_q = m[3:0];
    @(negedge clk);
    chk(flags_q == exp_q, "R8 stored flags", {60'd0, flags_q}, {60'd0, exp_q});
  endtask

  logic [63:0] vals [8];

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    vals[0] = 64'd0;                 vals[1] = 64'd1;
    vals[2] = 64'h7FFF_FFFF_FFFF_FFFF; vals[3] = 64'h8000_0000_0000_0000;
    vals[4] = 64'hFFFF_FFFF_FFFF_FFFF; vals[5] = 64'h0123_4567_89AB_CDEF;
    vals[6] = 64'hF0F0_F0F0_F0F0_F0F0; vals[7] = 64'h5555_5555_AAAA_AAAA;

    rst_n = 1'b0; op_sel = 3'd1; opa = 64'd0; opb = 64'd1; shamt = '0; set_flags = 1'b1;
    exp_q = 4'b0000;
    repeat (3) @(posedge clk);
    #2;
    // R9: held in reset despite a flag-setting subtract
    chk(flags_q == 4'b0000, "R9 reset", {60'd0, flags_q}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Named corners
    run(3'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 6'd0, 1'b1);
    chk(flags_q == 4'b1001, "R6 max+1 overflow", {60'd0, flags_q}, 64'h9);
    run(3'd1, 64'd0, 64'd1, 6'd0, 1'b1);
    chk(flags_q == 4'b1000, "R7 0-1 borrow", {60'd0, flags_q}, 64'h8);
    run(3'd1, 64'h1234, 64'h1234, 6'd0, 1'b1);
    chk(flags_q == 4'b0110, "R2 x-x zero", {60'd0, flags_q}, 64'h6);
    run(3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 6'd0, 1'b0);
    chk(flags_q == 4'b0110, "R8 no set_flags keeps", {60'd0, flags_q}, 64'h6);
    run(3'd5, 64'd0, 64'd5, 6'd3, 1'b1);
    chk(flags_q == 4'b0110, "R8 shift ignores set_flags", {60'd0, flags_q}, 64'h6);
    run(3'd7, 64'hDEAD, 64'hBEEF, 6'd9, 1'b0);

    // All value pairs through every operation
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run(3'(op), vals[i], vals[j], 6'(i * 9 + j), ((i + j + op) % 2) == 0);

    // Every shift amount both ways; opb varies to show it has no effect
    for (int s = 0; s < 64; s++) begin
      run(3'd5, 64'h8421_0FED_CBA9_1357, 64'(s) * 64'h9E37_79B9, 6'(s), 1'b1);
      run(3'd6, 64'h8421_0FED_CBA9_1357, ~64'(s), 6'(s), 1'b1);
    end

    // R9: asynchronous clear mid-run
    run(3'd0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 6'd0, 1'b1);
    chk(flags_q == 4'b0111, "R9 pre-reset flags", {60'd0, flags_q}, 64'h7);
    @(negedge clk);
    set_flags = 1'b0;
    #1 rst_n = 1'b0;
    #2;
    chk(flags_q == 4'b0000, "R9 async clear", {60'd0, flags_q}, 64'd0);
    exp_q = 4'b0000;
    @(negedge clk);
    rst_n = 1'b1;
    run(3'd2, 64'hFF00, 64'h0FF0, 6'd0, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule